// File: doc/BRIEF.md
# Host Serial Access Mode Controller

This block sits between a host processor and the bit-level core of a power-line FSK modem. Two level-sensitive selection pins choose one of four operating modes: sending data, receiving data, reading the control register and writing the control register. The block routes the host's transmit line to the modulator bit input. It routes the demodulator bit output, or register read data, to the host's receive line. It also drives the shared bit-clock line.

A single access-timing input, taken from one bit of the control register, selects the timing for both directions. In synchronous access the block makes the bit timing itself. During transmit it divides the system clock down to the selected baud rate and samples the host's transmit line on each rising edge of the bit clock it drives. During receive it runs a counter that restarts on every demodulator transition, samples the demodulated level at mid-bit and raises the bit clock at that moment. In asynchronous access both data paths are plain wires and the host does its own timing.

Whenever the receive line has nothing valid to carry, it is held at an idle level set by the interface-type pin: low for a clocked serial host link and high for a UART host link. This covers a missing carrier, the transmit and register-write modes, and register reads with no bit being shifted out.

Top module: `host_link_ctrl`

## Requirements
- R1: The mode follows the current level of {ctlSel, dirSel} in the same cycle. 00 is transmit (modEn=1), 01 is receive, 11 is register read (regRdEn=1) and 10 is register write (regWrEn=1). Exactly one of these is active at a time.
- R2: In synchronous transmit (syncAccess=1), bitClk runs with a period of BASE_DIV>>baudSel clock cycles. It stays high for half of that period, rounded down.
- R3: In synchronous transmit, modBit takes the value txData held at the clock edge where bitClk rises. Between rises it does not change.
- R4: In asynchronous transmit (syncAccess=0), modBit equals txData in the same cycle, and bitClk stays low.
- R5: In receive mode with carrierOk=0, rxData equals the idle level: 0 when uartSel=0 and 1 when uartSel=1.
- R6: In asynchronous receive with carrierOk=1, rxData equals demodBit in the same cycle.
- R7: In synchronous receive, every demodBit transition restarts the bit timer. The level is sampled (BASE_DIV>>baudSel)/2 cycles after the transition, and bitClk rises at that point. rxData changes only at those rises, or when carrierOk changes.
- R8: Outside transmit mode, modEn=0 and modBit=0. bitClk is low in asynchronous access and in both register modes.
- R9: In register read, rxData equals regOutBit while regOutValid=1 and the idle level otherwise. In register write, regWrBit equals txData and rxData is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlSel | input | 1 | Mode pin: 1 selects a register mode |
| dirSel | input | 1 | Mode pin: direction selection |
| syncAccess | input | 1 | Access timing from the control register: 1 = synchronous |
| uartSel | input | 1 | Interface type: 0 = clocked serial (idle low), 1 = UART (idle high) |
| baudSel | input | 2 | Baud select; divisor = BASE_DIV >> baudSel |
| txData | input | 1 | Host transmit data line |
| bitClk | output | 1 | Bit clock to the host |
| rxData | output | 1 | Host receive data line |
| modBit | output | 1 | Bit to the FSK modulator |
| modEn | output | 1 | Modulator input enable |
| demodBit | input | 1 | Bit from the FSK demodulator |
| carrierOk | input | 1 | Valid carrier present |
| regOutValid | input | 1 | Register shifter is driving a read bit |
| regOutBit | input | 1 | Register read data bit |
| regRdEn | output | 1 | Register read mode active |
| regWrEn | output | 1 | Register write mode active |
| regWrBit | output | 1 | Register write data bit |

## Verification
Some relations are checked on every cycle: the quiet modulator and bitClk outside their modes, the idle receive level without carrier, and the modulator bit holding steady between transmit clock rises. The same holds for the receive line holding between recovered clock rises. Only the bench scenarios can show the bit-clock period and duty at each baud selection, and that each rise carries the transmit value present at its edge. The same is true for mid-bit sampling after transitions that arrive early or late, and for the per-mode routing of register data.

// File: rtl/hlc_pkg.sv
package hlc_pkg;

  typedef enum logic [1:0] {
    MODE_TX = 2'b00,
    MODE_RX = 2'b01,
    MODE_WR = 2'b10,
    MODE_RD = 2'b11
  } modeT;

  typedef struct packed {
    logic txSync;
    logic txAsync;
    logic rxSync;
    logic rxAsync;
    logic regRd;
    logic regWr;
    logic idleLvl;
  } strobeT;

endpackage

// File: rtl/hlc_ctrl.sv
module hlc_ctrl
  import hlc_pkg::*;
(
  input  logic   ctlSel,
  input  logic   dirSel,
  input  logic   syncAccess,
  input  logic   uartSel,
  output strobeT strobes
);

  modeT mode;

  always_comb begin
    mode = modeT'({ctlSel, dirSel});
    strobes = '0;
    strobes.idleLvl = uartSel;
    unique case (mode)
      MODE_TX: begin
        strobes.txSync  = syncAccess;
        strobes.txAsync = !syncAccess;
      end
      MODE_RX: begin
        strobes.rxSync  = syncAccess;
        strobes.rxAsync = !syncAccess;
      end
      MODE_RD: strobes.regRd = 1'b1;
      MODE_WR: strobes.regWr = 1'b1;
      default: strobes.regWr = 1'b0;
    endcase
  end

endmodule

// File: rtl/hlc_tx_path.sv
module hlc_tx_path
  import hlc_pkg::*;
#(
  parameter int BASE_DIV = 26667,
  parameter int CNT_W    = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     strobes,
  input  logic [1:0] baudSel,
  input  logic       txData,
  output logic       txClk,
  output logic       modBit,
  output logic       modEn,
  output logic       regWrBit
);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLen;
  logic [CNT_W-1:0] divHalf;
  logic             txClkQ;
  logic             txBitQ;

  assign divLen  = CNT_W'(BASE_DIV) >> baudSel;
  assign divHalf = divLen >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      txClkQ <= 1'b0;
      txBitQ <= 1'b0;
    end else if (!strobes.txSync) begin
      divCnt <= '0;
      txClkQ <= 1'b0;
    end else if (divCnt >= divLen - 1'b1) begin
      divCnt <= '0;
      txClkQ <= 1'b1;
      txBitQ <= txData;
    end else begin
      divCnt <= divCnt + 1'b1;
      if (divCnt == divHalf - 1'b1) txClkQ <= 1'b0;
    end
  end

  always_comb begin
    modBit = 1'b0;
    if (strobes.txSync)       modBit = txBitQ;
    else if (strobes.txAsync) modBit = txData;
  end

  assign modEn    = strobes.txSync | strobes.txAsync;
  assign txClk    = txClkQ;
  assign regWrBit = strobes.regWr ? txData : 1'b0;

  // R3: the modulated bit only moves on a transmit clock rise
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.txSync && $past(strobes.txSync) && !$rose(txClkQ)) |-> $stable(modBit));

endmodule

// File: rtl/hlc_rx_path.sv
module hlc_rx_path
  import hlc_pkg::*;
#(
  parameter int BASE_DIV = 26667,
  parameter int CNT_W    = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     strobes,
  input  logic [1:0] baudSel,
  input  logic       demodBit,
  input  logic       carrierOk,
  input  logic       regOutValid,
  input  logic       regOutBit,
  output logic       rxClk,
  output logic       rxData
);

  logic [CNT_W-1:0] recCnt;
  logic [CNT_W-1:0] divLen;
  logic [CNT_W-1:0] divHalf;
  logic             demodPrev;
  logic             rxClkQ;
  logic             rxBitQ;
  logic             edgeSeen;

  assign divLen   = CNT_W'(BASE_DIV) >> baudSel;
  assign divHalf  = divLen >> 1;
  assign edgeSeen = demodBit ^ demodPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      demodPrev <= 1'b0;
      recCnt    <= '0;
      rxClkQ    <= 1'b0;
      rxBitQ    <= 1'b0;
    end else begin
      demodPrev <= demodBit;
      if (!strobes.rxSync) begin
        recCnt <= '0;
        rxClkQ <= 1'b0;
        rxBitQ <= strobes.idleLvl;
      end else if (edgeSeen) begin
        recCnt <= '0;
        rxClkQ <= 1'b0;
      end else begin
        if (recCnt >= divLen - 1'b1) begin
          recCnt <= '0;
          rxClkQ <= 1'b0;
        end else begin
          recCnt <= recCnt + 1'b1;
        end
        if (recCnt == divHalf - 1'b1) begin
          rxClkQ <= 1'b1;
          rxBitQ <= demodBit;
        end
      end
    end
  end

  always_comb begin
    rxData = strobes.idleLvl;
    if (strobes.rxSync && carrierOk)       rxData = rxBitQ;
    else if (strobes.rxAsync && carrierOk) rxData = demodBit;
    else if (strobes.regRd && regOutValid) rxData = regOutBit;
  end

  assign rxClk = rxClkQ;

  // R7: recovered data only changes on a recovered clock rise
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxSync && $past(strobes.rxSync) && carrierOk && $past(carrierOk)
     && !$rose(rxClkQ)) |-> $stable(rxData));

endmodule

// File: rtl/host_link_ctrl.sv
module host_link_ctrl
  import hlc_pkg::*;
#(
  parameter int BASE_DIV = 26667,
  localparam int CNT_W   = $clog2(BASE_DIV + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlSel,
  input  logic       dirSel,
  input  logic       syncAccess,
  input  logic       uartSel,
  input  logic [1:0] baudSel,
  input  logic       txData,
  output logic       bitClk,
  output logic       rxData,
  output logic       modBit,
  output logic       modEn,
  input  logic       demodBit,
  input  logic       carrierOk,
  input  logic       regOutValid,
  input  logic       regOutBit,
  output logic       regRdEn,
  output logic       regWrEn,
  output logic       regWrBit
);

  strobeT strobes;
  logic   txClk;
  logic   rxClk;

  hlc_ctrl u_ctrl (
    .ctlSel    (ctlSel),
    .dirSel    (dirSel),
    .syncAccess(syncAccess),
    .uartSel   (uartSel),
    .strobes   (strobes)
  );

  hlc_tx_path #(.BASE_DIV(BASE_DIV), .CNT_W(CNT_W)) u_tx (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .baudSel (baudSel),
    .txData  (txData),
    .txClk   (txClk),
    .modBit  (modBit),
    .modEn   (modEn),
    .regWrBit(regWrBit)
  );

  hlc_rx_path #(.BASE_DIV(BASE_DIV), .CNT_W(CNT_W)) u_rx (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .baudSel    (baudSel),
    .demodBit   (demodBit),
    .carrierOk  (carrierOk),
    .regOutValid(regOutValid),
    .regOutBit  (regOutBit),
    .rxClk      (rxClk),
    .rxData     (rxData)
  );

  assign bitClk  = strobes.txSync ? txClk : (strobes.rxSync ? rxClk : 1'b0);
  assign regRdEn = strobes.regRd;
  assign regWrEn = strobes.regWr;

  // R8: modulator quiet outside transmit
  p_mod_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSel || dirSel) |-> (!modEn && !modBit));

  // R8: no bit clock in asynchronous access or register modes
  p_clk_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSel || !syncAccess) |-> !bitClk);

  // R5: idle receive level without carrier
  p_rx_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlSel && dirSel && !carrierOk) |-> (rxData == uartSel));

  // R1: at most one register strobe, never together with transmit
  p_mode_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({modEn, regRdEn, regWrEn}));

endmodule

// File: tb/tb_host_link_ctrl.sv
`timescale 1ns/1ps
module tb_host_link_ctrl;

  localparam int BASE = 48;

  logic clk = 1'b0;
  logic rstN, ctlSel, dirSel, syncAccess, uartSel, txData;
  logic demodBit, carrierOk, regOutValid, regOutBit;
  logic [1:0] baudSel;
  logic bitClk, rxData, modBit, modEn, regRdEn, regWrEn, regWrBit;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  host_link_ctrl #(.BASE_DIV(BASE)) dut (
    .clk(clk), .rstN(rstN), .ctlSel(ctlSel), .dirSel(dirSel),
    .syncAccess(syncAccess), .uartSel(uartSel), .baudSel(baudSel),
    .txData(txData), .bitClk(bitClk), .rxData(rxData), .modBit(modBit),
    .modEn(modEn), .demodBit(demodBit), .carrierOk(carrierOk),
    .regOutValid(regOutValid), .regOutBit(regOutBit), .regRdEn(regRdEn),
    .regWrEn(regWrEn), .regWrBit(regWrBit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setMode(input logic c, input logic d);
    @(negedge clk);
    ctlSel = c;
    dirSel = d;
    #1;
  endtask

  task automatic t_reset;
    rstN = 0; ctlSel = 1; dirSel = 1; syncAccess = 1; uartSel = 0;
    baudSel = 0; txData = 0; demodBit = 0; carrierOk = 0;
    regOutValid = 0; regOutBit = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(bitClk == 0 && modEn == 0 && rxData == 0, "R8 reset", int'(bitClk), 0);
  endtask

  task automatic t_mode_decode;
    setMode(0, 0);
    chk(modEn && !regRdEn && !regWrEn, "R1 tx", int'({modEn, regRdEn, regWrEn}), 4);
    setMode(0, 1);
    chk(!modEn && !regRdEn && !regWrEn, "R1 rx", int'({modEn, regRdEn, regWrEn}), 0);
    setMode(1, 1);
    chk(!modEn && regRdEn && !regWrEn, "R1 rd", int'({modEn, regRdEn, regWrEn}), 2);
    setMode(1, 0);
    chk(!modEn && !regRdEn && regWrEn, "R1 wr", int'({modEn, regRdEn, regWrEn}), 1);
  endtask

  task automatic t_sync_tx(input logic [1:0] b);
    int div = BASE >> b;
    logic [7:0] pat = 8'b1011_0010;
    logic prev;
    int rises = 0, lastRise = -1, cyc = 0, highCnt = 0, expBit;
    syncAccess = 1;
    baudSel = b;
    setMode(0, 0);
    txData = pat[0];
    expBit = pat[0];
    prev = bitClk;
    while (rises < 8 && cyc < 20 * BASE) begin
      @(negedge clk);
      cyc++;
      if (bitClk) highCnt++;
      if (bitClk && !prev) begin
        chk(modBit == expBit, "R3 sample at rise", int'(modBit), expBit);
        if (lastRise >= 0) begin
          chk(cyc - lastRise == div, "R2 period", cyc - lastRise, div);
          chk(highCnt == div / 2 + 1, "R2 high time", highCnt - 1, div / 2);
        end
        lastRise = cyc;
        highCnt = 1;
        rises++;
        txData = pat[rises % 8];
        expBit = pat[rises % 8];
      end else if (rises > 0) begin
        chk(modBit == pat[(rises - 1) % 8], "R3 hold", int'(modBit), int'(pat[(rises - 1) % 8]));
      end
      prev = bitClk;
    end
    chk(rises == 8, "R2 rises", rises, 8);
  endtask

  task automatic t_async_tx;
    syncAccess = 0;
    setMode(0, 0);
    for (int i = 0; i < 4; i++) begin
      txData = logic'(i[0]);
      #1;
      chk(modBit == txData, "R4 passthrough", int'(modBit), int'(txData));
      chk(bitClk == 0, "R4 no clock", int'(bitClk), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_idle;
    syncAccess = 0;
    carrierOk = 0;
    setMode(0, 1);
    for (int u = 0; u < 2; u++) begin
      uartSel = logic'(u);
      demodBit = ~logic'(u);
      #1;
      chk(rxData == logic'(u), "R5 idle level", int'(rxData), u);
      @(negedge clk);
    end
    syncAccess = 1;
    uartSel = 1;
    demodBit = 0;
    repeat (BASE) @(negedge clk);
    chk(rxData == 1, "R5 idle sync", int'(rxData), 1);
    chk(modEn == 0 && modBit == 0, "R8 rx quiet mod", int'(modEn), 0);
  endtask

  task automatic t_async_rx;
    syncAccess = 0;
    carrierOk = 1;
    uartSel = 1;
    setMode(0, 1);
    for (int i = 0; i < 4; i++) begin
      demodBit = logic'(i[1] ^ i[0]);
      #1;
      chk(rxData == demodBit, "R6 async rx", int'(rxData), int'(demodBit));
      @(negedge clk);
    end
  endtask

  task automatic t_sync_rx;
    int lens[6] = '{48, 48, 30, 60, 48, 36};
    logic bits[6] = '{1, 0, 1, 0, 0, 1};
    logic prev;
    int risesSeen;
    syncAccess = 1;
    baudSel = 0;
    uartSel = 0;
    carrierOk = 1;
    setMode(0, 1);
    demodBit = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      demodBit = bits[k];
      risesSeen = 0;
      prev = bitClk;
      for (int c = 0; c < lens[k] - 4; c++) begin
        @(negedge clk);
        if (bitClk && !prev) risesSeen++;
        prev = bitClk;
      end
      chk(rxData == bits[k], "R7 mid-bit sample", int'(rxData), int'(bits[k]));
      if (lens[k] < 72)
        chk(risesSeen == 1, "R7 one recovered rise", risesSeen, 1);
      repeat (4) @(negedge clk);
    end
    carrierOk = 0;
    #1;
    chk(rxData == 0, "R5 carrier loss", int'(rxData), 0);
    carrierOk = 1;
  endtask

  task automatic t_reg_access;
    uartSel = 1;
    syncAccess = 1;
    setMode(1, 1);
    regOutValid = 0;
    regOutBit = 0;
    #1;
    chk(rxData == 1, "R9 read idle", int'(rxData), 1);
    regOutValid = 1;
    #1;
    chk(rxData == 0, "R9 read bit 0", int'(rxData), 0);
    regOutBit = 1;
    #1;
    chk(rxData == 1, "R9 read bit 1", int'(rxData), 1);
    repeat (BASE) @(negedge clk);
    chk(bitClk == 0, "R8 read no clock", int'(bitClk), 0);
    regOutValid = 0;
    setMode(1, 0);
    uartSel = 0;
    for (int i = 0; i < 2; i++) begin
      txData = logic'(i);
      #1;
      chk(regWrBit == txData, "R9 write bit", int'(regWrBit), int'(txData));
      chk(rxData == 0, "R9 write idle", int'(rxData), 0);
      chk(modEn == 0 && modBit == 0, "R8 write quiet", int'(modBit), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_mode_decode();
    for (int b = 0; b < 4; b++) t_sync_tx(2'(b));
    t_async_tx();
    t_idle();
    t_async_rx();
    t_sync_rx();
    t_reg_access();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule